// File: doc/BRIEF.md
# Autonegotiation Link Timer

This block times the link interval used by a gigabit PCS autonegotiation engine. A start request loads a terminal count and the timer begins to run. When the programmed number of prescaled units has passed, the timer raises a single-cycle expiry pulse and returns to idle. The count is kept in coarse units of 2^PRESCALE_W core clocks; the default of 10 bits gives units of 1024 clocks. A free 10-bit prescaler produces the unit ticks, so the main counter stays narrow.

The terminal count comes from one of two places. If the override enable is high, the software-supplied count is used. Otherwise the block derives a default from the core clock frequency in MHz and the selected mode. The default interval is 10 ms when the 1000BASE-X mode is selected and 1.6 ms in SGMII mode. The derived count is the interval in microseconds times the frequency in MHz, shifted right by PRESCALE_W. A new start while the timer runs restarts the interval. An abort stops the timer silently.

Top module: `an_link_timer`

## Requirements
- R1: After a synchronous reset, `running_o` and `expire_o` are both 0 and stay 0 until a start is taken.
- R2: A start with no abort in the same cycle sets `running_o` to 1 on the next clock edge, clears the prescaler and captures the terminal count N.
- R3: With terminal count N, `expire_o` rises exactly 2^PRESCALE_W*(N+1) clock edges after the edge that took the start. N = 0 therefore expires on the first prescaler tick.
- R4: `expire_o` is high for exactly one cycle, and `running_o` falls on the same edge at which `expire_o` rises.
- R5: When `ovr_en_i` is 1 at the start, N equals `ovr_count_i` as sampled at that start. Later changes of `ovr_count_i` or `ovr_en_i` do not affect the interval already running.
- R6: When `ovr_en_i` is 0, N equals (US*`clk_mhz_i`) >> PRESCALE_W. US is LONG_US (10000) when `mode_basex_i` = 1 (1000BASE-X) and SHORT_US (1600) when `mode_basex_i` = 0 (SGMII). The mode and frequency must be stable for at least one cycle before the start.
- R7: A derived count larger than 2^CNT_W-1 saturates to 2^CNT_W-1.
- R8: A start while running reloads N and restarts the full interval from the new start edge. This holds even on the edge where expiry would occur; in that case no expiry pulse is produced.
- R9: An abort sets `running_o` to 0 on the next edge with no expiry pulse. Abort takes priority over a start in the same cycle.
- R10: `running_o` only rises on the edge after a start is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_basex_i | input | 1 | 1 selects the 1000BASE-X interval, 0 the SGMII interval |
| clk_mhz_i | input | MHZ_W | Core clock frequency in MHz |
| ovr_en_i | input | 1 | Use the software count instead of the derived default |
| ovr_count_i | input | CNT_W | Software terminal count in prescaled units |
| start_i | input | 1 | Start or restart the interval |
| abort_i | input | 1 | Stop the timer without expiry |
| expire_o | output | 1 | One-cycle pulse when the interval has elapsed |
| running_o | output | 1 | Timer is counting |

## Verification
On every cycle the assertions check the cycle-level control rules. These are the single-cycle width of the expiry pulse, idle at the moment of expiry, the next-cycle effect of abort and start, and that running never rises without a start. The exact interval length can only be shown by the bench scenarios. The same holds for the default arithmetic in both modes, saturation, restart (including restart on the expiry edge) and the insulation of a running interval from later override changes. The bench shows these by sweeping a small prescaler and counter configuration and comparing measured edge counts against arithmetic in the bench.

// File: rtl/an_link_timer_pkg.sv
package an_link_timer_pkg;

  typedef enum logic {
    LT_IDLE = 1'b0,
    LT_RUN  = 1'b1
  } lt_state_e;

  localparam int LT_US_W = 32;

endpackage

// File: rtl/an_lt_defcalc.sv
module an_lt_defcalc #(
  parameter int MHZ_W      = 12,
  parameter int CNT_W      = 16,
  parameter int PRESCALE_W = 10,
  parameter int LONG_US    = 10000,
  parameter int SHORT_US   = 1600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_basex_i,
  input  logic [MHZ_W-1:0] clk_mhz_i,
  output logic [CNT_W-1:0] default_q_o
);
  import an_link_timer_pkg::*;

  localparam int PROD_W  = LT_US_W + MHZ_W;
  localparam int SCALE_W = PROD_W - PRESCALE_W;

  logic [LT_US_W-1:0] us_sel;
  logic [PROD_W-1:0]  prod;
  logic [PROD_W-1:0]  scaled;
  logic [CNT_W-1:0]   default_d;

  always_comb begin
    us_sel = mode_basex_i ? LT_US_W'(LONG_US) : LT_US_W'(SHORT_US);
    prod   = PROD_W'(us_sel) * PROD_W'(clk_mhz_i);
    scaled = prod >> PRESCALE_W;
  end

  generate
    if (SCALE_W > CNT_W) begin : g_sat
      localparam logic [PROD_W-1:0] CNT_LIMIT = PROD_W'({CNT_W{1'b1}});
      always_comb begin
        if (scaled > CNT_LIMIT) default_d = {CNT_W{1'b1}};
        else                    default_d = scaled[CNT_W-1:0];
      end
    end else begin : g_nosat
      always_comb default_d = CNT_W'(scaled);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) default_q_o <= '0;
    else     default_q_o <= default_d;
  end

endmodule

// File: rtl/an_lt_prescaler.sv
module an_lt_prescaler #(
  parameter int PRESCALE_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic enable_i,
  output logic tick_o
);
  logic [PRESCALE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) pre_q <= '0;
    else if (enable_i)  pre_q <= pre_q + 1'b1;
  end

  assign tick_o = enable_i && (pre_q == {PRESCALE_W{1'b1}});

endmodule

// File: rtl/an_lt_core.sv
module an_lt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] term_sel_i,
  output logic             expire_o,
  output logic             running_o
);
  import an_link_timer_pkg::*;

  lt_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= LT_IDLE;
      cnt_q    <= '0;
      term_q   <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (abort_i) begin
        state_q <= LT_IDLE;
      end else if (start_i) begin
        state_q <= LT_RUN;
        cnt_q   <= '0;
        term_q  <= term_sel_i;
      end else if (state_q == LT_RUN && tick_i) begin
        if (cnt_q == term_q) begin
          state_q  <= LT_IDLE;
          expire_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign running_o = (state_q == LT_RUN);

endmodule

// File: rtl/an_link_timer.sv
module an_link_timer #(
  parameter int MHZ_W      = 12,
  parameter int CNT_W      = 16,
  parameter int PRESCALE_W = 10,
  parameter int LONG_US    = 10000,
  parameter int SHORT_US   = 1600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_basex_i,
  input  logic [MHZ_W-1:0] clk_mhz_i,
  input  logic             ovr_en_i,
  input  logic [CNT_W-1:0] ovr_count_i,
  input  logic             start_i,
  input  logic             abort_i,
  output logic             expire_o,
  output logic             running_o
);
  logic [CNT_W-1:0] default_q;
  logic [CNT_W-1:0] term_sel;
  logic             tick;
  logic             pre_clear;
  logic             pre_en;

  an_lt_defcalc #(
    .MHZ_W(MHZ_W), .CNT_W(CNT_W), .PRESCALE_W(PRESCALE_W),
    .LONG_US(LONG_US), .SHORT_US(SHORT_US)
  ) defcalc_i (
    .clk(clk), .rst(rst), .mode_basex_i(mode_basex_i),
    .clk_mhz_i(clk_mhz_i), .default_q_o(default_q)
  );

  assign term_sel  = ovr_en_i ? ovr_count_i : default_q;
  assign pre_clear = start_i || abort_i;
  assign pre_en    = running_o && !pre_clear;

  an_lt_prescaler #(.PRESCALE_W(PRESCALE_W)) pre_i (
    .clk(clk), .rst(rst), .clear_i(pre_clear),
    .enable_i(pre_en), .tick_o(tick)
  );

  an_lt_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i),
    .tick_i(tick), .term_sel_i(term_sel),
    .expire_o(expire_o), .running_o(running_o)
  );

endmodule

// File: rtl/an_link_timer_chk.sv
module an_link_timer_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic abort_i,
  input logic expire_o,
  input logic running_o
);
  // R4
  expire_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !expire_o);
  // R4
  expire_idle_chk: assert property (@(posedge clk) disable iff (rst)
    expire_o |-> !running_o);
  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!running_o && !expire_o));
  // R2
  start_run_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !abort_i) |=> (running_o && !expire_o));
  // R10
  run_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(running_o) |-> $past(start_i));
endmodule

bind an_link_timer an_link_timer_chk chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .abort_i(abort_i),
  .expire_o(expire_o), .running_o(running_o)
);

// File: tb/an_link_timer_tb_top.sv
module an_link_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ_W = 4;
  localparam int CNT_W = 5;
  localparam int PRE_W = 3;
  localparam int P     = 1 << PRE_W;
  localparam int L_US  = 40;
  localparam int S_US  = 6;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_basex_i = 1'b0;
  logic [MHZ_W-1:0] clk_mhz_i = '0;
  logic ovr_en_i = 1'b0;
  logic [CNT_W-1:0] ovr_count_i = '0;
  logic start_i = 1'b0;
  logic abort_i = 1'b0;
  logic expire_o, running_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  an_link_timer #(
    .MHZ_W(MHZ_W), .CNT_W(CNT_W), .PRESCALE_W(PRE_W),
    .LONG_US(L_US), .SHORT_US(S_US)
  ) dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present start for one edge; returns at the negedge after that edge.
  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // From the point just after the start edge, wait for expiry and check timing.
  task automatic wait_expiry(input int exp_k, input string req);
    int k = 0;
    bit early_idle = 0;
    while (k < 2000) begin
      @(negedge clk);
      k++;
      if (expire_o) break;
      if (!running_o) early_idle = 1;
    end
    check(expire_o && k == exp_k, req, k, exp_k);
    check(!early_idle && !running_o, "R4 running", running_o, 0);
    @(negedge clk);
    check(!expire_o, "R4 width", expire_o, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!running_o && !expire_o, "R1", {running_o, expire_o}, 0);

    // R3 R5: override sweep over every terminal count
    ovr_en_i = 1'b1;
    for (int n = 0; n <= CMAX; n++) begin
      ovr_count_i = CNT_W'(n);
      @(negedge clk);
      pulse_start();
      check(running_o, "R2", running_o, 1);
      wait_expiry(P * (n + 1), "R3/R5 override");
    end

    // R6 R7: derived default in both modes, every frequency
    ovr_en_i = 1'b0;
    for (int m = 0; m < 2; m++) begin
      for (int f = 0; f < (1 << MHZ_W); f++) begin
        int nexp;
        mode_basex_i = m[0];
        clk_mhz_i = MHZ_W'(f);
        nexp = ((m == 1 ? L_US : S_US) * f) >> PRE_W;
        if (nexp > CMAX) nexp = CMAX;
        repeat (2) @(negedge clk);
        pulse_start();
        wait_expiry(P * (nexp + 1), m == 1 ? "R6/R7 basex" : "R6 sgmii");
      end
    end

    // R5 override change mid run has no effect
    ovr_en_i = 1'b1;
    ovr_count_i = 5'd4;
    @(negedge clk);
    pulse_start();
    repeat (4) @(negedge clk);
    ovr_count_i = 5'd20;
    ovr_en_i = 1'b0;
    wait_expiry(P * 5 - 4, "R5 midrun");
    ovr_en_i = 1'b1;

    // R8 restart mid run
    ovr_count_i = 5'd5;
    @(negedge clk);
    pulse_start();
    repeat (20) @(negedge clk);
    check(!expire_o && running_o, "R8 pre", expire_o, 0);
    pulse_start();
    wait_expiry(P * 6, "R8 restart");

    // R8 restart on the expiry edge
    ovr_count_i = 5'd2;
    @(negedge clk);
    pulse_start();
    repeat (P * 3 - 1) @(negedge clk);
    pulse_start();
    check(!expire_o, "R8 expiry edge pulse", expire_o, 0);
    check(running_o, "R8 expiry edge run", running_o, 1);
    wait_expiry(P * 3, "R8 expiry edge");

    // R9 abort mid run
    ovr_count_i = 5'd3;
    @(negedge clk);
    pulse_start();
    repeat (10) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    check(!running_o && !expire_o, "R9 abort", running_o, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (expire_o || running_o) seen++;
      end
      check(seen == 0, "R9 silent", seen, 0);
    end

    // R9 abort wins over start; R10 running stays low
    abort_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    start_i = 1'b0;
    check(!running_o, "R9/R10 priority", running_o, 0);
    repeat (5) @(negedge clk);
    check(!running_o && !expire_o, "R10 idle", running_o, 0);

    // R1 reset during a run
    pulse_start();
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!running_o && !expire_o, "R1 midrun", running_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule